// File: doc/BRIEF.md
# Debug Instruction Scan Chain

This block is the serial register a debug host uses to feed a halted processor core one instruction at a time and to read results back. The chain is thirty-three cells long: a 32-bit field that carries an instruction or a data word, and one extra cell above it that carries a speed-select flag. When that flag is set, the instruction that follows runs at full system speed instead of the slow debug speed. An exchange of one word takes 33 shift clocks. The tap controller that sequences the strobes lies outside the block, and so do the pipeline and memory.

The host moves bits in and out least-significant first, and the speed cell is the last cell filled. A capture strobe loads the core's data bus into the word field and the present speed flag into the top cell. An update strobe moves the whole chain into parallel holding registers that feed the core. At that moment the block also sorts the new instruction into a class and raises a flag if it may not run in debug state, or if it carries the speed flag when it is not a memory transfer. The outputs move only on update.

Top module: `dbg_instr_chain`

## Requirements
- R1: After reset, instrOut, speedOut, illegalOut and tdo are all 0.
- R2: In a cycle with shiftEn, and without captureEn, every cell takes the value of the cell above it. tdi enters the speed cell (bit 32) and tdo always shows cell 0. After 33 shifts, the first bit sent sits in cell 0 and the last bit sent sits in the speed cell.
- R3: In a cycle with captureEn, cells 31:0 load dataBusIn and cell 32 loads the present speedOut. Shifting out then gives the data bits LSB first, followed by that speed value.
- R4: In a cycle with updateEn, and without captureEn or shiftEn, instrOut takes cells 31:0 and speedOut takes cell 32. illegalOut is refreshed for the new word. All three appear one clock later.
- R5: instrOut, speedOut and illegalOut keep their values in every cycle without an effective update, and that includes cycles of capture and of shifting.
- R6: The strobes have a fixed priority: capture first, then shift, then update. A lower strobe that is asserted in the same cycle as a higher one has no effect.
- R7: A data-processing word is legal when its speed flag is 0. Such a word has bits[27:26]=00, is not a multiply or extra-load pattern ([25]=0, [7]=1, [4]=1), and is not a compare without flag setting ([24:23]=10, [20]=0). Example: 0xE0810002.
- R8: A single transfer has bits[27:26]=01 and is not the pattern [25]=1 with [4]=1. A block transfer has bits[27:25]=100. Both are legal whatever the speed flag.
- R9: Status-register transfers are legal when the speed flag is 0. The read form has [27:23]=00010, [21:20]=00 and [7:4]=0000. The register write form has [27:23]=00010, [21:20]=10 and [7:4]=0000. The immediate write form has [27:23]=00110 and [21:20]=10.
- R10: Every other word raises illegalOut whatever the speed flag. This includes branches ([27:25]=101), coprocessor and trap words ([27:26]=11), multiplies, branch-exchange and undefined transfer patterns.
- R11: A data-processing or status-register word that is updated with the speed flag set raises illegalOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the strobes act as clock enables |
| rstN | input | 1 | Active-low asynchronous reset |
| shiftEn | input | 1 | Shift the chain one cell toward bit 0 |
| captureEn | input | 1 | Load the data bus and speed flag into the chain |
| updateEn | input | 1 | Move the chain into the holding registers |
| tdi | input | 1 | Serial data in, entering the speed cell |
| tdo | output | 1 | Serial data out, taken from cell 0 |
| dataBusIn | input | 32 | Core data bus value for capture |
| instrOut | output | 32 | Held instruction word to the core |
| speedOut | output | 1 | Held speed flag: the next instruction runs at system speed |
| illegalOut | output | 1 | Held word may not run in debug state, or carries the speed flag illegally |

## Verification
The bench sends memory transfers with the speed flag set and other classes with it set. A design that applied the speed rule to every class, or to no class, would mark the wrong words illegal. It places words at the edges of the classes: a compare that sets flags next to a status read, branch-exchange beside a status write, a multiply in the data-processing space, and the undefined transfer pattern. A decoder with a loose mask would accept these. It captures a pattern while the speed flag is held high and reads it back bit by bit. That catches a reversed shift order, a speed bit dropped from capture, or outputs that move while shifting. Last, it asserts strobe pairs together, which shows whether a lower-priority strobe leaks through.

// File: rtl/dbg_instr_chain_pkg.sv
package dbg_instr_chain_pkg;

  // Per-cycle action requested of the datapath; at most one bit set.
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } chainStrobes_t;

  // Instruction classes seen at update time.
  typedef enum logic [2:0] {
    CLS_DATA   = 3'd0,
    CLS_SINGLE = 3'd1,
    CLS_BLOCK  = 3'd2,
    CLS_PSR    = 3'd3,
    CLS_OTHER  = 3'd4
  } instrClass_e;

endpackage

// File: rtl/dbg_instr_chain_ctrl.sv
module dbg_instr_chain_ctrl
  import dbg_instr_chain_pkg::*;
(
  input  logic          captureEn,
  input  logic          shiftEn,
  input  logic          updateEn,
  output chainStrobes_t strb
);

  // Fixed priority: capture, then shift, then update.
  always_comb begin
    strb = '0;
    if (captureEn) begin
      strb.capture = 1'b1;
    end else if (shiftEn) begin
      strb.shift = 1'b1;
    end else if (updateEn) begin
      strb.update = 1'b1;
    end
  end

endmodule

// File: rtl/dbg_instr_decoder.sv
module dbg_instr_decoder
  import dbg_instr_chain_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] instr,
  output instrClass_e       instrClass
);

  logic isMulOrExtra;
  logic isMiscSpace;
  logic isPsrRead;
  logic isPsrWriteReg;
  logic isPsrWriteImm;
  logic isUndefXfer;

  assign isMulOrExtra  = !instr[25] && instr[7] && instr[4];
  assign isMiscSpace   = (instr[24:23] == 2'b10) && !instr[20];
  assign isPsrRead     = !instr[25] && (instr[21:20] == 2'b00) && (instr[7:4] == 4'b0000);
  assign isPsrWriteReg = !instr[25] && (instr[21:20] == 2'b10) && (instr[7:4] == 4'b0000);
  assign isPsrWriteImm =  instr[25] && (instr[21:20] == 2'b10);
  assign isUndefXfer   =  instr[25] && instr[4];

  always_comb begin
    instrClass = CLS_OTHER;
    unique case (instr[27:26])
      2'b00: begin
        if (isMulOrExtra) begin
          instrClass = CLS_OTHER;
        end else if (isMiscSpace) begin
          if (isPsrRead || isPsrWriteReg || isPsrWriteImm) begin
            instrClass = CLS_PSR;
          end else begin
            instrClass = CLS_OTHER;
          end
        end else begin
          instrClass = CLS_DATA;
        end
      end
      2'b01: instrClass = isUndefXfer ? CLS_OTHER : CLS_SINGLE;
      2'b10: instrClass = instr[25] ? CLS_OTHER : CLS_BLOCK;
      default: instrClass = CLS_OTHER;
    endcase
  end

  logic unusedBits;
  assign unusedBits = ^{instr[DATA_W-1:28], instr[22], instr[19:8], instr[6:5], instr[3:0]};

endmodule

// File: rtl/dbg_instr_chain_dp.sv
module dbg_instr_chain_dp
  import dbg_instr_chain_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  chainStrobes_t       strb,
  input  logic                tdi,
  input  logic [DATA_W-1:0]   dataBusIn,
  output logic                tdo,
  output logic [DATA_W-1:0]   instrOut,
  output logic                speedOut,
  output logic                illegalOut,
  output logic [DATA_W:0]     chainBits
);

  localparam int CHAIN_W = DATA_W + 1;
  localparam int SPEED_B = DATA_W;

  logic [CHAIN_W-1:0] chainQ;
  logic [CHAIN_W-1:0] captureVal;
  logic [CHAIN_W-1:0] shiftVal;
  instrClass_e        newClass;
  logic               newIllegal;
  logic               isMemClass;

  assign captureVal = {speedOut, dataBusIn};
  assign shiftVal   = {tdi, chainQ[CHAIN_W-1:1]};

  // One cell per chain bit.
  for (genvar b = 0; b < CHAIN_W; b++) begin : g_cell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chainQ[b] <= 1'b0;
      end else if (strb.capture) begin
        chainQ[b] <= captureVal[b];
      end else if (strb.shift) begin
        chainQ[b] <= shiftVal[b];
      end
    end
  end

  dbg_instr_decoder #(.DATA_W(DATA_W)) dec_i (
    .instr      (chainQ[DATA_W-1:0]),
    .instrClass (newClass)
  );

  assign isMemClass = (newClass == CLS_SINGLE) || (newClass == CLS_BLOCK);
  assign newIllegal = (newClass == CLS_OTHER) || (chainQ[SPEED_B] && !isMemClass);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrOut   <= '0;
      speedOut   <= 1'b0;
      illegalOut <= 1'b0;
    end else if (strb.update) begin
      instrOut   <= chainQ[DATA_W-1:0];
      speedOut   <= chainQ[SPEED_B];
      illegalOut <= newIllegal;
    end
  end

  assign tdo       = chainQ[0];
  assign chainBits = chainQ;

endmodule

// File: rtl/dbg_instr_chain.sv
module dbg_instr_chain
  import dbg_instr_chain_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftEn,
  input  logic              captureEn,
  input  logic              updateEn,
  input  logic              tdi,
  output logic              tdo,
  input  logic [DATA_W-1:0] dataBusIn,
  output logic [DATA_W-1:0] instrOut,
  output logic              speedOut,
  output logic              illegalOut
);

  chainStrobes_t     strb;
  logic [DATA_W:0]   chainBits;

  dbg_instr_chain_ctrl ctrl_i (
    .captureEn (captureEn),
    .shiftEn   (shiftEn),
    .updateEn  (updateEn),
    .strb      (strb)
  );

  dbg_instr_chain_dp #(.DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .tdi        (tdi),
    .dataBusIn  (dataBusIn),
    .tdo        (tdo),
    .instrOut   (instrOut),
    .speedOut   (speedOut),
    .illegalOut (illegalOut),
    .chainBits  (chainBits)
  );

endmodule

// File: rtl/dbg_instr_chain_chk.sv
module dbg_instr_chain_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              shiftEn,
  input logic              captureEn,
  input logic              updateEn,
  input logic              tdi,
  input logic              tdo,
  input logic [DATA_W-1:0] dataBusIn,
  input logic [DATA_W-1:0] instrOut,
  input logic              speedOut,
  input logic              illegalOut,
  input logic [DATA_W:0]   chainBits
);

  logic doShift;
  logic doUpdate;
  logic memWord;

  assign doShift  = shiftEn && !captureEn;
  assign doUpdate = updateEn && !captureEn && !shiftEn;
  assign memWord  = (instrOut[27:26] == 2'b01) || (instrOut[27:25] == 3'b100);

  // R1: outputs low while reset is held
  always_comb begin
    if (!rstN) begin
      a_reset_r1: assert (instrOut == '0 && !speedOut && !illegalOut && !tdo);
    end
  end

  // R2: shift moves the chain toward bit 0 with tdi at the top
  p_shift_r2: assert property (@(posedge clk) disable iff (!rstN)
    doShift |=> chainBits == {$past(tdi), $past(chainBits[DATA_W:1])});

  // R3: capture loads the bus and the held speed flag
  p_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |=> chainBits == {$past(speedOut), $past(dataBusIn)});

  // R4: update copies the chain into the holding registers
  p_update_r4: assert property (@(posedge clk) disable iff (!rstN)
    doUpdate |=> (instrOut == $past(chainBits[DATA_W-1:0])) && (speedOut == $past(chainBits[DATA_W])));

  // R5 and R6: no effective update leaves the outputs alone
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !doUpdate |=> $stable(instrOut) && $stable(speedOut) && $stable(illegalOut));

  // R6: an update strobe under a higher strobe leaves the outputs alone
  p_priority_r6: assert property (@(posedge clk) disable iff (!rstN)
    (updateEn && (captureEn || shiftEn)) |=> $stable(instrOut) && $stable(speedOut));

  // R11: a speed flag accepted as legal only sits on memory transfers
  p_speed_mem_r11: assert property (@(posedge clk) disable iff (!rstN)
    (speedOut && !illegalOut) |-> memWord);

endmodule

bind dbg_instr_chain dbg_instr_chain_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .shiftEn    (shiftEn),
  .captureEn  (captureEn),
  .updateEn   (updateEn),
  .tdi        (tdi),
  .tdo        (tdo),
  .dataBusIn  (dataBusIn),
  .instrOut   (instrOut),
  .speedOut   (speedOut),
  .illegalOut (illegalOut),
  .chainBits  (chainBits)
);

// File: tb/dbg_instr_chain_tb_top.sv
module dbg_instr_chain_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        shiftEn = 1'b0;
  logic        captureEn = 1'b0;
  logic        updateEn = 1'b0;
  logic        tdi = 1'b0;
  logic        tdo;
  logic [31:0] dataBusIn = '0;
  logic [31:0] instrOut;
  logic        speedOut;
  logic        illegalOut;

  int checks = 0;
  int errors = 0;

  logic [33:0] expQ[$];   // {instr, speed, illegal}
  string       tagQ[$];
  logic        updPending = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  dbg_instr_chain dut_i (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .captureEn(captureEn),
    .updateEn(updateEn), .tdi(tdi), .tdo(tdo), .dataBusIn(dataBusIn),
    .instrOut(instrOut), .speedOut(speedOut), .illegalOut(illegalOut)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench view of an effective update, from its own drive.
  always @(posedge clk) updPending <= rstN && updateEn && !captureEn && !shiftEn;

  // Monitor: compare the scoreboard head once the outputs have moved.
  always @(negedge clk) begin
    if (updPending) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected update actual=%h expected=none", {instrOut, speedOut, illegalOut});
      end else begin
        logic [33:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {30'd0, instrOut, speedOut, illegalOut}, {30'd0, e});
      end
    end
  end

  task automatic shiftWord(input logic [32:0] inBits, output logic [32:0] outBits);
    for (int i = 0; i < 33; i++) begin
      @(negedge clk);
      outBits[i] = tdo;
      shiftEn = 1'b1;
      tdi = inBits[i];
    end
    @(negedge clk);
    shiftEn = 1'b0;
    tdi = 1'b0;
  endtask

  task automatic doUpdate(input logic [31:0] ins, input logic spd, input logic ill, input string tag);
    expQ.push_back({ins, spd, ill});
    tagQ.push_back(tag);
    updateEn = 1'b1;
    @(negedge clk);
    updateEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic loadWord(input logic [31:0] ins, input logic spd, input logic ill, input string tag);
    logic [32:0] dummy;
    shiftWord({spd, ins}, dummy);
    doUpdate(ins, spd, ill, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [32:0] got;
    logic [33:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset outputs", {30'd0, instrOut, speedOut, illegalOut, tdo}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R7 / R11: data processing
    loadWord(32'hE0810002, 1'b0, 1'b0, "R7 add legal");
    loadWord(32'hE0810002, 1'b1, 1'b1, "R11 add with speed");
    loadWord(32'hE1100001, 1'b0, 1'b0, "R7 flag-setting compare");
    loadWord(32'hE0000291, 1'b0, 1'b1, "R10 multiply");
    // R8: memory transfers
    loadWord(32'hE5910000, 1'b1, 1'b0, "R8 single load with speed");
    loadWord(32'hE7810002, 1'b0, 1'b0, "R8 register-offset store");
    loadWord(32'hE7810012, 1'b0, 1'b1, "R10 undefined transfer");
    loadWord(32'hE8BD000F, 1'b1, 1'b0, "R8 block load with speed");
    // R9 / R11: status transfers
    loadWord(32'hE10F0000, 1'b0, 1'b0, "R9 status read");
    loadWord(32'hE10F0000, 1'b1, 1'b1, "R11 status read with speed");
    loadWord(32'hE129F000, 1'b0, 1'b0, "R9 status write reg");
    loadWord(32'hE329F01F, 1'b0, 1'b0, "R9 status write imm");
    // R10: other classes
    loadWord(32'hE12FFF11, 1'b0, 1'b1, "R10 branch exchange");
    loadWord(32'hEA000000, 1'b0, 1'b1, "R10 branch");
    loadWord(32'hEE010F10, 1'b1, 1'b1, "R10 coprocessor");
    loadWord(32'hEF000000, 1'b0, 1'b1, "R10 trap");

    // R3 / R2 / R5: capture with the speed flag high, read back
    loadWord(32'hE5910000, 1'b1, 1'b0, "R8 load sets speed");
    held = {instrOut, speedOut, illegalOut};
    dataBusIn = 32'hA5C30F96;
    captureEn = 1'b1;
    @(negedge clk);
    captureEn = 1'b0;
    check("R5 outputs after capture", {30'd0, instrOut, speedOut, illegalOut}, {30'd0, held});
    shiftWord({1'b0, 32'hE8BD000F}, got);
    check("R3 captured bits out LSB first", {31'd0, got}, {31'd0, 1'b1, 32'hA5C30F96});
    check("R5 outputs after shifting", {30'd0, instrOut, speedOut, illegalOut}, {30'd0, held});
    doUpdate(32'hE8BD000F, 1'b0, 1'b0, "R2 word shifted in");

    // R6: capture wins over shift
    dataBusIn = 32'h12345678;
    captureEn = 1'b1;
    shiftEn = 1'b1;
    tdi = 1'b1;
    @(negedge clk);
    captureEn = 1'b0;
    shiftEn = 1'b0;
    tdi = 1'b0;
    shiftWord({1'b1, 32'hEA000000}, got);
    check("R6 capture over shift", {31'd0, got}, {31'd0, 1'b0, 32'h12345678});
    // R6: shift wins over update
    held = {instrOut, speedOut, illegalOut};
    shiftEn = 1'b1;
    updateEn = 1'b1;
    @(negedge clk);
    shiftEn = 1'b0;
    updateEn = 1'b0;
    @(negedge clk);
    check("R6 update under shift ignored", {30'd0, instrOut, speedOut, illegalOut}, {30'd0, held});
    // R6: capture wins over update
    captureEn = 1'b1;
    updateEn = 1'b1;
    @(negedge clk);
    captureEn = 1'b0;
    updateEn = 1'b0;
    @(negedge clk);
    check("R6 update under capture ignored", {30'd0, instrOut, speedOut, illegalOut}, {30'd0, held});
    // R4: the chain now holds the capture {speed 0, 12345678}
    doUpdate(32'h12345678, 1'b0, 1'b0, "R4 update of captured word");

    repeat (2) @(negedge clk);
    check("R4 scoreboard drained", {32'd0, expQ.size()}, 64'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule